// File: doc/BRIEF.md
# Paired-Access General Register File

This block holds the thirty-two 32-bit general registers of a 32-bit core. Two single-register read ports and one single-register write port serve ordinary integer instructions. A third path reads and writes two registers as one 64-bit operand. Instructions that work on double-precision floats or 64-bit integers on a 32-bit datapath use this path.

The same storage can also be reached through the special-purpose register address space. A special-purpose address is a group number shifted left by 11 and ORed with an index within that group. The general registers occupy a 32-entry window of the system group. The program counter and the previous program counter are also visible in that group.

A small program-counter unit keeps the current PC. It saves the old value as the previous PC on every PC load.

The second register of a pair is found with a stride that depends on bit 5 of the 6-bit pair index. With bit 5 clear, the second register is the next register up. With bit 5 set, it is two registers up. The wider stride lets pairs in the upper half skip over registers that the calling convention preserves.

Top module: `regpair_top`

## Requirements
- R1: The file holds 32 registers of 32 bits. The two single read ports return the addressed register combinationally. A single write (`wr_en`) updates the addressed register on the rising clock edge.
- R2: Register 0 always reads zero. Writes to index 0 from the single, pair or special-purpose path leave it at zero.
- R3: For a 6-bit pair index p, the first register is p[4:0]. The second register is p[4:0]+2 when p[5] is 1 and p[4:0]+1 when p[5] is 0, modulo 32. Index 31 with p[5]=0 therefore pairs with register 0, and index 63 pairs with register 1.
- R4: A pair read returns the first register in bits 63:32 and the second register in bits 31:0, combinationally.
- R5: A pair write (`pr_wr_en`) stores bits 63:32 into the first register and bits 31:0 into the second register on the clock edge.
- R6: When several write paths target one register in the same cycle, the pair write wins. The special-purpose write beats the single write.
- R7: A special-purpose address is 16 bits: group in bits 15:11, index in bits 10:0. System group 0, indices 0x400 to 0x41F, alias registers 0 to 31. Reads and writes there use the same storage as the other ports. The same index in any other group does not hit the registers.
- R8: In the system group, a special-purpose read of index 0x010 returns the PC and index 0x012 returns the previous PC. Every other address outside the register window (for example 0x011 and 0x014) reads zero. A special-purpose write to 0x012, or to any unmapped address, changes no state.
- R9: A PC load copies the current PC into the previous PC and loads the new value in the same edge. A PC load comes from `pc_wr_en`, or from a special-purpose write to index 0x010 of the system group, with `pc_wr_en` taking priority. Without a load both hold.
- R10: A synchronous active-high reset clears all registers, the PC and the previous PC, and overrides any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Single write enable |
| wr_idx | input | 5 | Single write register index |
| wr_data | input | 32 | Single write data |
| pr_rd_idx | input | 6 | Pair read index |
| pr_rd_data | output | 64 | Pair read data, first register high |
| pr_wr_en | input | 1 | Pair write enable |
| pr_wr_idx | input | 6 | Pair write index |
| pr_wr_data | input | 64 | Pair write data, high half to first register |
| spr_addr | input | 16 | Special-purpose address (group, index) |
| spr_wr_en | input | 1 | Special-purpose write enable |
| spr_wr_data | input | 32 | Special-purpose write data |
| spr_rd_data | output | 32 | Special-purpose read data |
| pc_wr_en | input | 1 | PC load enable |
| pc_wr_data | input | 32 | New PC value |
| pc_q | output | 32 | Current PC |
| ppc_q | output | 32 | Previous PC |

## Verification
Directed pair indices 31, 63 and 0x30 separate the two strides and the wrap to register 0 or 1. They also show that a pair half landing on register 0 is dropped. Same-cycle writes from all three paths to one register expose the priority order. The same window index in a non-system group shows whether the group field is decoded. Random cycles mix every write path with reads through all three views of the storage, including the PC, previous-PC and reserved system indices. A model computed in the bench then catches any disagreement between the aliases.

// File: rtl/regpair_pkg.sv
`timescale 1ns/1ps
package regpair_pkg;
    localparam int unsigned NREG      = 32;
    localparam int unsigned XLEN      = 32;
    localparam int unsigned RAW       = $clog2(NREG);
    localparam int unsigned SPR_AW    = 16;
    localparam int unsigned SPR_SHIFT = 11;
    localparam int unsigned SYS_GROUP = 0;
    localparam int unsigned GPR_BASE  = 'h400;
    localparam int unsigned NPC_IX    = 'h010;
    localparam int unsigned PPC_IX    = 'h012;

    typedef enum logic [1:0] {
        SK_NONE = 2'd0,
        SK_GPR  = 2'd1,
        SK_NPC  = 2'd2,
        SK_PPC  = 2'd3
    } spr_kind_e;

    typedef struct packed {
        spr_kind_e          kind;
        logic [RAW-1:0]     gidx;
    } spr_hit_t;

    typedef struct packed {
        logic [RAW-1:0] first;
        logic [RAW-1:0] second;
    } pair_sel_t;

    function automatic pair_sel_t pair_split(input logic [RAW:0] p);
        pair_sel_t s;
        s.first  = p[RAW-1:0];
        s.second = p[RAW-1:0] + (p[RAW] ? RAW'(2) : RAW'(1));
        return s;
    endfunction
endpackage

// File: rtl/regpair_pair_map.sv
`timescale 1ns/1ps
module regpair_pair_map
    import regpair_pkg::*;
(
    input  logic [RAW:0] pidx,
    output pair_sel_t    sel
);
    assign sel = pair_split(pidx);
endmodule

// File: rtl/regpair_spr_decode.sv
`timescale 1ns/1ps
module regpair_spr_decode
    import regpair_pkg::*;
#(
    parameter int unsigned AW    = SPR_AW,
    parameter int unsigned SHIFT = SPR_SHIFT
) (
    input  logic [AW-1:0] addr,
    output spr_hit_t      hit
);
    localparam int unsigned GW = AW - SHIFT;
    localparam logic [GW-1:0]    SYS_G  = GW'(SYS_GROUP);
    localparam logic [SHIFT-1:0] BASE_W = SHIFT'(GPR_BASE);
    localparam logic [SHIFT-1:0] NPC_W  = SHIFT'(NPC_IX);
    localparam logic [SHIFT-1:0] PPC_W  = SHIFT'(PPC_IX);

    logic [GW-1:0]    grp;
    logic [SHIFT-1:0] ix;
    logic             in_sys;

    assign grp    = addr[AW-1:SHIFT];
    assign ix     = addr[SHIFT-1:0];
    assign in_sys = (grp == SYS_G);

    // The register window is aligned to its size, so its upper index bits select it.
    always_comb begin
        hit.gidx = ix[RAW-1:0];
        hit.kind = SK_NONE;
        if (in_sys) begin
            if (ix[SHIFT-1:RAW] == BASE_W[SHIFT-1:RAW]) hit.kind = SK_GPR;
            else if (ix == NPC_W)                       hit.kind = SK_NPC;
            else if (ix == PPC_W)                       hit.kind = SK_PPC;
        end
    end
endmodule

// File: rtl/regpair_pc_unit.sv
`timescale 1ns/1ps
module regpair_pc_unit
    import regpair_pkg::*;
#(
    parameter int unsigned W = XLEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pc_we,
    input  logic [W-1:0] pc_wd,
    output logic [W-1:0] pc_q,
    output logic [W-1:0] ppc_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ppc_q <= '0;
        end else if (pc_we) begin
            ppc_q <= pc_q;
            pc_q  <= pc_wd;
        end
    end

    p_pc_shift_r9: assert property (@(posedge clk) disable iff (rst)
        pc_we |=> (ppc_q == $past(pc_q)) && (pc_q == $past(pc_wd)));
    p_pc_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !pc_we |=> $stable(pc_q) && $stable(ppc_q));
    p_pc_reset_r10: assert property (@(posedge clk)
        rst |=> (pc_q == '0) && (ppc_q == '0));
endmodule

// File: rtl/regpair_store.sv
`timescale 1ns/1ps
module regpair_store
    import regpair_pkg::*;
#(
    parameter int unsigned N   = NREG,
    parameter int unsigned W   = XLEN,
    parameter int unsigned NRD = 5
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NRD-1:0][$clog2(N)-1:0]     rd_idx,
    output logic [NRD-1:0][W-1:0]             rd_data,
    input  logic                              s_en,
    input  logic [$clog2(N)-1:0]              s_idx,
    input  logic [W-1:0]                      s_data,
    input  logic                              a_en,
    input  logic [$clog2(N)-1:0]              a_idx,
    input  logic [W-1:0]                      a_data,
    input  logic                              p_en,
    input  logic [$clog2(N)-1:0]              p_first,
    input  logic [$clog2(N)-1:0]              p_second,
    input  logic [W-1:0]                      p_hi,
    input  logic [W-1:0]                      p_lo
);
    localparam int unsigned AW = $clog2(N);

    logic [N-1:0][W-1:0] regs;
    logic [N-1:0][W-1:0] wd;
    logic [N-1:0]        we;

    // Per-register write merge: pair halves first, then alias path, then single port.
    for (genvar i = 0; i < N; i++) begin : g_wmux
        if (i == 0) begin : g_zero
            assign we[i] = 1'b0;
            assign wd[i] = '0;
        end else begin : g_live
            logic hit_pf, hit_ps, hit_a, hit_s;
            assign hit_pf = p_en && (p_first  == AW'(i));
            assign hit_ps = p_en && (p_second == AW'(i));
            assign hit_a  = a_en && (a_idx    == AW'(i));
            assign hit_s  = s_en && (s_idx    == AW'(i));
            assign we[i]  = hit_pf | hit_ps | hit_a | hit_s;
            assign wd[i]  = hit_pf ? p_hi :
                            hit_ps ? p_lo :
                            hit_a  ? a_data : s_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst)        regs[i] <= '0;
            else if (we[i]) regs[i] <= wd[i];
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_data[r] = regs[rd_idx[r]];
    end

    p_r0_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_idx[0] == '0) |-> (rd_data[0] == '0));
    p_single_write_r1: assert property (@(posedge clk) disable iff (rst)
        (s_en && s_idx != '0 && !(a_en && a_idx == s_idx)
              && !(p_en && (p_first == s_idx || p_second == s_idx)))
        |=> regs[$past(s_idx)] == $past(s_data));
    p_pair_hi_r5: assert property (@(posedge clk) disable iff (rst)
        (p_en && p_first != '0) |=> regs[$past(p_first)] == $past(p_hi));
    p_pair_lo_r5: assert property (@(posedge clk) disable iff (rst)
        (p_en && p_second != '0) |=> regs[$past(p_second)] == $past(p_lo));
    p_alias_over_single_r6: assert property (@(posedge clk) disable iff (rst)
        (a_en && s_en && a_idx == s_idx && a_idx != '0
              && !(p_en && (p_first == a_idx || p_second == a_idx)))
        |=> regs[$past(a_idx)] == $past(a_data));
endmodule

// File: rtl/regpair_top.sv
`timescale 1ns/1ps
module regpair_top
    import regpair_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [4:0]      rd_a_idx,
    output logic [31:0]     rd_a_data,
    input  logic [4:0]      rd_b_idx,
    output logic [31:0]     rd_b_data,
    input  logic            wr_en,
    input  logic [4:0]      wr_idx,
    input  logic [31:0]     wr_data,
    input  logic [5:0]      pr_rd_idx,
    output logic [63:0]     pr_rd_data,
    input  logic            pr_wr_en,
    input  logic [5:0]      pr_wr_idx,
    input  logic [63:0]     pr_wr_data,
    input  logic [15:0]     spr_addr,
    input  logic            spr_wr_en,
    input  logic [31:0]     spr_wr_data,
    output logic [31:0]     spr_rd_data,
    input  logic            pc_wr_en,
    input  logic [31:0]     pc_wr_data,
    output logic [31:0]     pc_q,
    output logic [31:0]     ppc_q
);
    localparam int unsigned NRD = 5;

    pair_sel_t rsel, wsel;
    spr_hit_t  shit;
    logic [NRD-1:0][RAW-1:0]  rd_idx;
    logic [NRD-1:0][XLEN-1:0] rd_data;
    logic             pc_we;
    logic [XLEN-1:0]  pc_wd;

    regpair_pair_map u_rmap (.pidx(pr_rd_idx), .sel(rsel));
    regpair_pair_map u_wmap (.pidx(pr_wr_idx), .sel(wsel));
    regpair_spr_decode u_dec (.addr(spr_addr), .hit(shit));

    assign rd_idx[0] = rd_a_idx;
    assign rd_idx[1] = rd_b_idx;
    assign rd_idx[2] = rsel.first;
    assign rd_idx[3] = rsel.second;
    assign rd_idx[4] = shit.gidx;

    regpair_store #(.N(NREG), .W(XLEN), .NRD(NRD)) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .s_en     (wr_en),
        .s_idx    (wr_idx),
        .s_data   (wr_data),
        .a_en     (spr_wr_en && shit.kind == SK_GPR),
        .a_idx    (shit.gidx),
        .a_data   (spr_wr_data),
        .p_en     (pr_wr_en),
        .p_first  (wsel.first),
        .p_second (wsel.second),
        .p_hi     (pr_wr_data[63:32]),
        .p_lo     (pr_wr_data[31:0])
    );

    assign pc_we = pc_wr_en || (spr_wr_en && shit.kind == SK_NPC);
    assign pc_wd = pc_wr_en ? pc_wr_data : spr_wr_data;

    regpair_pc_unit #(.W(XLEN)) u_pc (
        .clk   (clk),
        .rst   (rst),
        .pc_we (pc_we),
        .pc_wd (pc_wd),
        .pc_q  (pc_q),
        .ppc_q (ppc_q)
    );

    assign rd_a_data  = rd_data[0];
    assign rd_b_data  = rd_data[1];
    assign pr_rd_data = {rd_data[2], rd_data[3]};

    always_comb begin
        unique case (shit.kind)
            SK_GPR:  spr_rd_data = rd_data[4];
            SK_NPC:  spr_rd_data = pc_q;
            SK_PPC:  spr_rd_data = ppc_q;
            default: spr_rd_data = '0;
        endcase
    end

    p_ppc_unwritable_r8: assert property (@(posedge clk) disable iff (rst)
        (spr_wr_en && shit.kind == SK_PPC && !pc_wr_en) |=> $stable(ppc_q));
    p_pair_read_order_r4: assert property (@(posedge clk) disable iff (rst)
        (pr_rd_idx[4:0] == 5'd0) |-> (pr_rd_data[63:32] == '0));
endmodule

// File: tb/tb_regpair_top.sv
`timescale 1ns/1ps
module tb_regpair_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst;
    logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic [31:0] rd_a_data, rd_b_data, wr_data;
    logic        wr_en, pr_wr_en, spr_wr_en, pc_wr_en;
    logic [5:0]  pr_rd_idx, pr_wr_idx;
    logic [63:0] pr_rd_data, pr_wr_data;
    logic [15:0] spr_addr;
    logic [31:0] spr_wr_data, spr_rd_data, pc_wr_data, pc_q, ppc_q;

    regpair_top dut (.*);

    int checks = 0, errors = 0;
    logic [31:0] m_regs [32];
    logic [31:0] m_pc, m_ppc;

    function automatic logic [4:0] f_first(input logic [5:0] p);
        return p[4:0];
    endfunction
    function automatic logic [4:0] f_second(input logic [5:0] p);
        return p[4:0] + (p[5] ? 5'd2 : 5'd1);
    endfunction
    function automatic logic [31:0] f_spr(input logic [15:0] a);
        if (a[15:11] != 5'd0)                 return 32'h0;
        if (a[10:0] >= 11'h400 && a[10:0] < 11'h420) return m_regs[a[4:0]];
        if (a[10:0] == 11'h010)               return m_pc;
        if (a[10:0] == 11'h012)               return m_ppc;
        return 32'h0;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; pr_wr_en = 0; spr_wr_en = 0; pc_wr_en = 0;
        wr_idx = 0; wr_data = 0; pr_wr_idx = 0; pr_wr_data = 0;
        spr_wr_data = 0; pc_wr_data = 0;
    endtask

    task automatic sample_all();
        check("R1 read port A", {32'h0, rd_a_data}, {32'h0, m_regs[rd_a_idx]});
        check("R1 read port B", {32'h0, rd_b_data}, {32'h0, m_regs[rd_b_idx]});
        check("R4 pair read", pr_rd_data,
              {m_regs[f_first(pr_rd_idx)], m_regs[f_second(pr_rd_idx)]});
        check("R7 R8 spr read", {32'h0, spr_rd_data}, {32'h0, f_spr(spr_addr)});
        check("R9 pc", {32'h0, pc_q}, {32'h0, m_pc});
        check("R9 ppc", {32'h0, ppc_q}, {32'h0, m_ppc});
    endtask

    task automatic model_update();
        if (wr_en && wr_idx != 0) m_regs[wr_idx] = wr_data;
        if (spr_wr_en && spr_addr[15:11] == 0 && spr_addr[10:0] >= 11'h400
            && spr_addr[10:0] < 11'h420 && spr_addr[4:0] != 0)
            m_regs[spr_addr[4:0]] = spr_wr_data;
        if (pr_wr_en) begin
            if (f_first(pr_wr_idx)  != 0) m_regs[f_first(pr_wr_idx)]  = pr_wr_data[63:32];
            if (f_second(pr_wr_idx) != 0) m_regs[f_second(pr_wr_idx)] = pr_wr_data[31:0];
        end
        if (pc_wr_en) begin
            m_ppc = m_pc; m_pc = pc_wr_data;
        end else if (spr_wr_en && spr_addr == 16'h0010) begin
            m_ppc = m_pc; m_pc = spr_wr_data;
        end
    endtask

    // Inputs are set just after a falling edge; this samples, clocks, updates the model.
    task automatic tick();
        #5 sample_all();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic peek_a(input logic [4:0] i, input string tag, input logic [31:0] exp);
        rd_a_idx = i;
        #1 check(tag, {32'h0, rd_a_data}, {32'h0, exp});
    endtask

    initial begin
        #(20ns * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 32; i++) m_regs[i] = 0;
        m_pc = 0; m_ppc = 0;
        idle();
        rd_a_idx = 0; rd_b_idx = 0; pr_rd_idx = 0; spr_addr = 0;
        rst = 1;
        // Writes held during reset must be overridden.
        wr_en = 1; wr_idx = 5'd3; wr_data = 32'hFFFF_FFFF; pc_wr_en = 1; pc_wr_data = 32'h55;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0; idle();
        for (int i = 0; i < 32; i += 3) peek_a(5'(i), "R10 register cleared by reset", 32'h0);
        check("R10 pc cleared", {32'h0, pc_q}, 64'h0);
        check("R10 ppc cleared", {32'h0, ppc_q}, 64'h0);

        // R2: writes to register 0 from all three paths.
        wr_en = 1; wr_idx = 0; wr_data = 32'hDEAD_BEEF;
        pr_wr_en = 1; pr_wr_idx = 6'd0; pr_wr_data = 64'hAAAA_0000_1111_2222;
        tick(); idle();
        spr_wr_en = 1; spr_addr = 16'h0400; spr_wr_data = 32'hCAFE_0000;
        tick(); idle();
        peek_a(5'd0, "R2 r0 stays zero", 32'h0);
        peek_a(5'd1, "R5 pair index 0 low half to r1", 32'h1111_2222);

        // R3: stride and wrap.
        pr_wr_en = 1; pr_wr_idx = 6'd31; pr_wr_data = 64'hA0A0_A0A0_B0B0_B0B0;
        tick(); idle();
        peek_a(5'd31, "R3 index 31 first reg", 32'hA0A0_A0A0);
        peek_a(5'd0,  "R3 index 31 wraps to r0, dropped", 32'h0);
        pr_wr_en = 1; pr_wr_idx = 6'd63; pr_wr_data = 64'hC0C0_C0C0_D0D0_D0D0;
        tick(); idle();
        peek_a(5'd31, "R5 index 63 high half to r31", 32'hC0C0_C0C0);
        peek_a(5'd1,  "R3 index 63 second is r1", 32'hD0D0_D0D0);
        wr_en = 1; wr_idx = 5'd17; wr_data = 32'h1717_1717;
        tick(); idle();
        pr_wr_en = 1; pr_wr_idx = 6'h30; pr_wr_data = 64'h1616_1616_1818_1818;
        tick(); idle();
        peek_a(5'd18, "R3 extended pair second is first+2", 32'h1818_1818);
        peek_a(5'd17, "R3 extended pair skips first+1", 32'h1717_1717);
        pr_rd_idx = 6'h30;
        #1 check("R4 extended pair read", pr_rd_data, 64'h1616_1616_1818_1818);

        // R6: priority.
        wr_en = 1; wr_idx = 5'd5; wr_data = 32'h0000_0051;
        spr_wr_en = 1; spr_addr = 16'h0405; spr_wr_data = 32'h0000_0052;
        pr_wr_en = 1; pr_wr_idx = 6'd4; pr_wr_data = 64'h0000_0044_0000_0053;
        tick(); idle();
        peek_a(5'd5, "R6 pair beats spr and single", 32'h0000_0053);
        wr_en = 1; wr_idx = 5'd7; wr_data = 32'h0000_0071;
        spr_wr_en = 1; spr_addr = 16'h0407; spr_wr_data = 32'h0000_0072;
        tick(); idle();
        peek_a(5'd7, "R6 spr beats single", 32'h0000_0072);

        // R7/R8/R9: the alias window and system indices.
        spr_wr_en = 1; spr_addr = 16'h0C05; spr_wr_data = 32'hBAD0_0005;
        tick(); idle();
        peek_a(5'd5, "R7 other group does not alias", 32'h0000_0053);
        spr_addr = 16'h0C05;
        #1 check("R8 other group reads zero", {32'h0, spr_rd_data}, 64'h0);
        pc_wr_en = 1; pc_wr_data = 32'h0000_1000;
        tick(); idle();
        spr_wr_en = 1; spr_addr = 16'h0010; spr_wr_data = 32'h0000_2000;
        tick(); idle();
        check("R9 spr npc write loads pc", {32'h0, pc_q}, {32'h0, 32'h0000_2000});
        check("R9 spr npc write saves ppc", {32'h0, ppc_q}, {32'h0, 32'h0000_1000});
        spr_wr_en = 1; spr_addr = 16'h0012; spr_wr_data = 32'hFFFF_0000;
        tick(); idle();
        check("R8 ppc write ignored", {32'h0, ppc_q}, {32'h0, 32'h0000_1000});
        spr_addr = 16'h0011;
        #1 check("R8 reserved index reads zero", {32'h0, spr_rd_data}, 64'h0);
        wr_en = 1; wr_idx = 5'd10; wr_data = 32'h0A0A_0A0A;
        tick(); idle();
        spr_addr = 16'h040A;
        #1 check("R7 window read sees single write", {32'h0, spr_rd_data}, {32'h0, 32'h0A0A_0A0A});

        // Random mix of all paths.
        for (int n = 0; n < 600; n++) begin
            logic [2:0] sel;
            rd_a_idx = 5'($urandom); rd_b_idx = 5'($urandom); pr_rd_idx = 6'($urandom);
            wr_en = 1'($urandom); wr_idx = 5'($urandom); wr_data = $urandom;
            pr_wr_en = ($urandom % 4) == 0; pr_wr_idx = 6'($urandom);
            pr_wr_data = {$urandom, $urandom};
            pc_wr_en = ($urandom % 5) == 0; pc_wr_data = $urandom;
            spr_wr_en = 1'($urandom); spr_wr_data = $urandom;
            sel = 3'($urandom);
            case (sel)
                3'd0, 3'd1, 3'd2: spr_addr = {5'd0, 6'b100000, 5'($urandom)};
                3'd3: spr_addr = 16'h0010;
                3'd4: spr_addr = 16'h0012;
                3'd5: spr_addr = (($urandom % 2) != 0) ? 16'h0011 : 16'h0014;
                default: spr_addr = {5'($urandom % 31) + 5'd1, 11'($urandom)};
            endcase
            tick();
        end
        idle();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule